// File: doc/BRIEF.md
# Dual Bit-Rate Strobe Generator

This block derives two independent bit-rate enable strobes, one for a serial receiver and one for a serial transmitter, from the system clock. A shared prescaler first divides the clock by three or by four, picked by one bit of a control word. Each channel then has an 11-bit rate word. Its top bit inserts an optional divide-by-eight stage. Its low ten bits give a divisor n. A final divide-by-two sets the strobe rate. The outputs are one-cycle enable pulses, not derived clocks, so downstream logic stays in the system clock domain.

The four configuration words share one data input: control, interval, receive rate and transmit rate. Each word has a pending-load flag. A load pulse writes the data into the highest-priority word whose flag is set, and then clears that flag. Reset sets all four flags, so after reset the words are written in a fixed order. Any subset of flags can be raised again with a request input, which allows single words to be rewritten later. The interval word is only stored and shown on an output, for use by a timer outside this block.

Top module: `dual_baud_gen`

## Requirements
- R1: While reset is asserted and right after it, all four pending flags read 1, the control and interval words read 0, and both strobes are low.
- R2: A load pulse writes only the lowest-indexed pending word and clears its flag. The flag bits map as follows: bit 0 is control (loadData[7:0]), bit 1 is interval (loadData[7:0]), bit 2 is the receive rate (loadData[10:0]) and bit 3 is the transmit rate (loadData[10:0]).
- R3: A load pulse while no flag is pending changes no word and does not disturb either strobe's rate.
- R4: reqLoad bit i sets pending flag i. A request in the same cycle as a load of that word leaves the flag set. No flag rises without a request.
- R5: Bit 3 of the control word selects the prescale: 0 divides by 3 and 1 divides by 4. Loading the control word restarts the prescaler.
- R6: In a rate word, bit 10 is the mode m and bits 9:0 are n. The strobe period in clock cycles is P * (m ? 8 : 1) * n * 2, where P is the prescale.
- R7: A divisor n of 0 acts as 1024.
- R8: The receive strobe follows only the receive rate word, and the transmit strobe follows only the transmit rate word.
- R9: Each strobe is high for exactly one clock cycle per period.
- R10: Loading a rate word restarts that channel. Its strobe is low in the cycle after the load, and the first strobe arrives between (2*M*N-1)*P+1 and 2*M*N*P cycles after the load edge, where M = m ? 8 : 1 and N is the effective divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| loadStrobe | input | 1 | Writes loadData into the highest-priority pending word |
| loadData | input | 11 | Shared configuration data |
| reqLoad | input | 4 | Sets the matching pending-load flags |
| ctrlWord | output | 8 | Current control word |
| intervalWord | output | 8 | Current interval word |
| pendLoad | output | 4 | Pending-load flags |
| rxTick | output | 1 | Receive bit-rate strobe |
| txTick | output | 1 | Transmit bit-rate strobe |

## Verification
The main stimulus is a sweep over both prescale settings, both mode bits and several small divisors. The receive and transmit channels get different divisors, so a swapped or shared channel shows up as a wrong period. Separate runs cover a zero divisor against a divisor of one, and loads with no pending flag, which tell the wrap-to-1024 case and the ignore path apart from normal loads. Each measured period is compared with the product formula. Each restart latency is checked against its window, and the window depends on whether the counters were cleared when the word was loaded.

// File: rtl/bdg_pkg.sv
package bdg_pkg;
  localparam int NUM_SLOTS = 4;
  localparam int SLOT_CTRL = 0;
  localparam int SLOT_IVL  = 1;
  localparam int SLOT_RX   = 2;
  localparam int SLOT_TX   = 3;
  localparam int NUM_CHAN  = 2;

  typedef struct packed {
    logic [NUM_SLOTS-1:0] load;
    logic                 preTick;
  } seqStrobes_t;
endpackage

// File: rtl/bdg_ctrl.sv
module bdg_ctrl
  import bdg_pkg::*;
#(
  parameter int PRE_LO = 3,
  parameter int PRE_HI = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 loadStrobe,
  input  logic [NUM_SLOTS-1:0] reqLoad,
  input  logic                 preSel,
  output logic [NUM_SLOTS-1:0] pendLoad,
  output seqStrobes_t          seq
);
  localparam int PRE_W = $clog2(PRE_HI);

  logic [NUM_SLOTS-1:0] grant;
  logic [PRE_W-1:0]     preCnt;
  logic [PRE_W-1:0]     preMax;
  logic                 preTick;

  // lowest set pending bit wins
  always_comb begin
    grant = '0;
    if (loadStrobe) grant = pendLoad & (~pendLoad + 1'b1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendLoad <= '1;
    else       pendLoad <= (pendLoad & ~grant) | reqLoad;
  end

  assign preMax  = preSel ? PRE_W'(PRE_HI - 1) : PRE_W'(PRE_LO - 1);
  assign preTick = (preCnt >= preMax);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                preCnt <= '0;
    else if (grant[SLOT_CTRL]) preCnt <= '0;
    else if (preTick)         preCnt <= '0;
    else                      preCnt <= preCnt + 1'b1;
  end

  assign seq.load    = grant;
  assign seq.preTick = preTick;
endmodule

// File: rtl/bdg_chan.sv
module bdg_chan #(
  parameter int DIV_W   = 10,
  parameter int OCT_DIV = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             restart,
  input  logic             preTick,
  input  logic             octMode,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  localparam int OCT_W = $clog2(OCT_DIV);

  logic [OCT_W-1:0] octCnt;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLast;
  logic             stageTick;
  logic             wrap;
  logic             half;

  assign stageTick = octMode ? (preTick && (octCnt == OCT_W'(OCT_DIV - 1))) : preTick;
  // zero divisor wraps to all ones, giving 2**DIV_W
  assign divLast   = divisor - 1'b1;
  assign wrap      = stageTick && (divCnt == divLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      octCnt <= '0;
      divCnt <= '0;
      half   <= 1'b0;
      tick   <= 1'b0;
    end else if (restart) begin
      octCnt <= '0;
      divCnt <= '0;
      half   <= 1'b0;
      tick   <= 1'b0;
    end else begin
      if (preTick)   octCnt <= octCnt + 1'b1;
      if (wrap)      divCnt <= '0;
      else if (stageTick) divCnt <= divCnt + 1'b1;
      if (wrap)      half <= ~half;
      tick <= wrap && half;
    end
  end
endmodule

// File: rtl/bdg_path.sv
module bdg_path
  import bdg_pkg::*;
#(
  parameter int DIV_W       = 10,
  parameter int CTRL_W      = 8,
  parameter int IVL_W       = 8,
  parameter int PRE_SEL_BIT = 3,
  parameter int OCT_DIV     = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobes_t         seq,
  input  logic [DIV_W:0]      loadData,
  output logic [CTRL_W-1:0]   ctrlWord,
  output logic [IVL_W-1:0]    intervalWord,
  output logic                preSel,
  output logic [NUM_CHAN-1:0] ticks
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlWord     <= '0;
      intervalWord <= '0;
    end else begin
      if (seq.load[SLOT_CTRL]) ctrlWord     <= loadData[CTRL_W-1:0];
      if (seq.load[SLOT_IVL])  intervalWord <= loadData[IVL_W-1:0];
    end
  end

  assign preSel = ctrlWord[PRE_SEL_BIT];

  for (genvar g = 0; g < NUM_CHAN; g++) begin : gChan
    logic [DIV_W:0] rateQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                     rateQ <= '0;
      else if (seq.load[SLOT_RX + g]) rateQ <= loadData;
    end
    bdg_chan #(.DIV_W(DIV_W), .OCT_DIV(OCT_DIV)) uChan (
      .clk     (clk),
      .rstN    (rstN),
      .restart (seq.load[SLOT_RX + g]),
      .preTick (seq.preTick),
      .octMode (rateQ[DIV_W]),
      .divisor (rateQ[DIV_W-1:0]),
      .tick    (ticks[g])
    );
  end
endmodule

// File: rtl/dual_baud_gen.sv
module dual_baud_gen
  import bdg_pkg::*;
#(
  parameter int DIV_W       = 10,
  parameter int CTRL_W      = 8,
  parameter int IVL_W       = 8,
  parameter int PRE_SEL_BIT = 3,
  parameter int PRE_LO      = 3,
  parameter int PRE_HI      = 4,
  parameter int OCT_DIV     = 8,
  localparam int RATE_W     = DIV_W + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 loadStrobe,
  input  logic [RATE_W-1:0]    loadData,
  input  logic [NUM_SLOTS-1:0] reqLoad,
  output logic [CTRL_W-1:0]    ctrlWord,
  output logic [IVL_W-1:0]     intervalWord,
  output logic [NUM_SLOTS-1:0] pendLoad,
  output logic                 rxTick,
  output logic                 txTick
);
  seqStrobes_t          seq;
  logic                 preSel;
  logic [NUM_CHAN-1:0]  ticks;

  bdg_ctrl #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .loadStrobe (loadStrobe),
    .reqLoad    (reqLoad),
    .preSel     (preSel),
    .pendLoad   (pendLoad),
    .seq        (seq)
  );

  bdg_path #(
    .DIV_W(DIV_W), .CTRL_W(CTRL_W), .IVL_W(IVL_W),
    .PRE_SEL_BIT(PRE_SEL_BIT), .OCT_DIV(OCT_DIV)
  ) uPath (
    .clk          (clk),
    .rstN         (rstN),
    .seq          (seq),
    .loadData     (loadData),
    .ctrlWord     (ctrlWord),
    .intervalWord (intervalWord),
    .preSel       (preSel),
    .ticks        (ticks)
  );

  assign rxTick = ticks[0];
  assign txTick = ticks[1];
endmodule

// File: rtl/dual_baud_gen_chk.sv
module dual_baud_gen_chk #(
  parameter int CTRL_W = 8,
  parameter int IVL_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              loadStrobe,
  input logic [CTRL_W-1:0] loadLow,
  input logic [3:0]        reqLoad,
  input logic [CTRL_W-1:0] ctrlWord,
  input logic [IVL_W-1:0]  intervalWord,
  input logic [3:0]        pendLoad,
  input logic              rxTick,
  input logic              txTick
);
  assert_rx_one_cycle_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxTick |=> !rxTick);
  assert_tx_one_cycle_R9: assert property (@(posedge clk) disable iff (!rstN)
    txTick |=> !txTick);
  assert_idle_load_ignored_R3: assert property (@(posedge clk) disable iff (!rstN)
    (loadStrobe && pendLoad == 4'b0000) |=> ($stable(ctrlWord) && $stable(intervalWord)));
  assert_ctrl_first_R2: assert property (@(posedge clk) disable iff (!rstN)
    (loadStrobe && pendLoad[0]) |=> (ctrlWord == $past(loadLow) && $stable(intervalWord)));
  assert_ivl_second_R2: assert property (@(posedge clk) disable iff (!rstN)
    (loadStrobe && pendLoad[1:0] == 2'b10 && !reqLoad[1])
      |=> (!pendLoad[1] && intervalWord == $past(loadLow[IVL_W-1:0]) && $stable(ctrlWord)));
  assert_no_spurious_flag_R4: assert property (@(posedge clk) disable iff (!rstN)
    (reqLoad == 4'b0000) |=> ((pendLoad & ~$past(pendLoad)) == 4'b0000));
  assert_rx_restart_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (loadStrobe && pendLoad[2:0] == 3'b100) |=> !rxTick);
endmodule

bind dual_baud_gen dual_baud_gen_chk #(.CTRL_W(CTRL_W), .IVL_W(IVL_W)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .loadStrobe   (loadStrobe),
  .loadLow      (loadData[CTRL_W-1:0]),
  .reqLoad      (reqLoad),
  .ctrlWord     (ctrlWord),
  .intervalWord (intervalWord),
  .pendLoad     (pendLoad),
  .rxTick       (rxTick),
  .txTick       (txTick)
);

// File: tb/dual_baud_gen_test.sv
`timescale 1ns/1ps
module dual_baud_gen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadStrobe = 1'b0;
  logic [10:0] loadData = '0;
  logic [3:0]  reqLoad = '0;
  logic [7:0]  ctrlWord;
  logic [7:0]  intervalWord;
  logic [3:0]  pendLoad;
  logic        rxTick;
  logic        txTick;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  dual_baud_gen uut (
    .clk(clk), .rstN(rstN), .loadStrobe(loadStrobe), .loadData(loadData),
    .reqLoad(reqLoad), .ctrlWord(ctrlWord), .intervalWord(intervalWord),
    .pendLoad(pendLoad), .rxTick(rxTick), .txTick(txTick)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doLoad(input logic [10:0] v);
    loadData   = v;
    loadStrobe = 1'b1;
    @(negedge clk);
    loadStrobe = 1'b0;
  endtask

  task automatic doReq(input logic [3:0] m);
    reqLoad = m;
    @(negedge clk);
    reqLoad = '0;
  endtask

  function automatic logic sel(input bit ch);
    return ch ? txTick : rxTick;
  endfunction

  // cycles from now until the chosen strobe is seen (0 if already high)
  task automatic waitTick(input bit ch, output int cnt);
    cnt = 0;
    while (!sel(ch) && cnt < 20000) begin
      @(negedge clk);
      cnt++;
    end
  endtask

  task automatic period(input bit ch, output int p);
    int dummy;
    waitTick(ch, dummy);
    @(negedge clk);
    p = 1;
    while (!sel(ch) && p < 20000) begin
      @(negedge clk);
      p++;
    end
  endtask

  initial begin
    #1_900_000ns;
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    int p, lat;
    repeat (4) @(negedge clk);
    // R1 during reset
    check(pendLoad == 4'hF, "R1 pend in reset", pendLoad, 15);
    rstN = 1'b1;
    @(negedge clk);
    check(pendLoad == 4'hF, "R1 pend", pendLoad, 15);
    check(ctrlWord == 0 && intervalWord == 0, "R1 words", ctrlWord, 0);
    check(!rxTick && !txTick, "R1 strobes", rxTick + txTick, 0);

    // R4: request and load of same word in one cycle
    reqLoad = 4'b0001;
    doLoad(11'h0AA);
    reqLoad = '0;
    check(ctrlWord == 8'hAA, "R2 ctrl written", ctrlWord, 8'hAA);
    check(pendLoad == 4'hF, "R4 flag kept", pendLoad, 15);

    doLoad(11'h008);
    check(ctrlWord == 8'h08, "R2 ctrl reload", ctrlWord, 8);
    check(pendLoad == 4'hE, "R2 ctrl flag cleared", pendLoad, 14);
    doLoad(11'h13C);
    check(intervalWord == 8'h3C, "R2 interval", intervalWord, 8'h3C);
    check(ctrlWord == 8'h08, "R2 ctrl untouched", ctrlWord, 8);
    check(pendLoad == 4'hC, "R2 ivl flag cleared", pendLoad, 12);
    doLoad({1'b0, 10'd5});
    check(pendLoad == 4'h8, "R2 rx flag cleared", pendLoad, 8);
    doLoad({1'b1, 10'd2});
    check(pendLoad == 4'h0, "R2 tx flag cleared", pendLoad, 0);

    // R3: load with nothing pending
    doLoad(11'h7FF);
    check(ctrlWord == 8'h08 && intervalWord == 8'h3C, "R3 words kept", ctrlWord, 8);
    check(pendLoad == 4'h0, "R3 pend stays clear", pendLoad, 0);
    period(1'b0, p);
    check(p == 40, "R3 rx period kept", p, 40);
    period(1'b1, p);
    check(p == 128, "R3 tx period kept", p, 128);

    // R4: re-request one word only
    doReq(4'b0010);
    check(pendLoad == 4'b0010, "R4 single request", pendLoad, 2);
    doLoad(11'h055);
    check(intervalWord == 8'h55 && ctrlWord == 8'h08, "R4 interval rewritten", intervalWord, 8'h55);
    check(pendLoad == 4'h0, "R4 flag cleared again", pendLoad, 0);

    // R5 R6 R8 R10 sweep
    for (int pre = 0; pre < 2; pre++) begin
      for (int m = 0; m < 2; m++) begin
        for (int n = 1; n < 5; n++) begin
          int pv, mv, nTx, expRx, expTx, lo, hi;
          pv  = pre ? 4 : 3;
          mv  = m ? 8 : 1;
          nTx = n + 3;
          expRx = pv * mv * n * 2;
          expTx = pv * mv * nTx * 2;
          doReq(4'b1101);
          doLoad(pre ? 11'h008 : 11'h0F7);
          doLoad({m[0], 10'(n)});
          doLoad({m[0], 10'(nTx)});
          check(!txTick, "R10 tx quiet after load", txTick, 0);
          waitTick(1'b1, lat);
          lo = (2 * mv * nTx - 1) * pv + 1;
          hi = 2 * mv * nTx * pv;
          check(lat >= lo && lat <= hi, "R10 tx restart latency", lat, hi);
          period(1'b0, p);
          check(p == expRx, "R5 R6 R8 rx period", p, expRx);
          period(1'b1, p);
          check(p == expTx, "R5 R6 R8 tx period", p, expTx);
        end
      end
    end

    // R7 zero divisor, R9 single-cycle strobe
    doReq(4'b1101);
    doLoad(11'h000);
    doLoad({1'b0, 10'd0});
    doLoad({1'b0, 10'd1});
    period(1'b1, p);
    check(p == 6, "R7 tx divisor one", p, 6);
    waitTick(1'b1, lat);
    @(negedge clk);
    check(!txTick, "R9 tx strobe width", txTick, 0);
    period(1'b0, p);
    check(p == 6144, "R7 rx divisor zero", p, 6144);
    @(negedge clk);
    check(!rxTick, "R9 rx strobe width", rxTick, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule